// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address of up to 52 bits. It walks a four-level radix tree of 64-bit descriptors held in memory. A requester hands over the virtual address, the physical base of the top-level table and three access attributes: write, user-mode and instruction fetch. The walker then issues one descriptor read per level on a simple request/response memory port. It ends with a single-cycle completion pulse that carries either the translated address or a fault code together with the level where the walk stopped.

The translated range is 48 bits. Each level consumes a 9-bit slice of the virtual address, starting with the slice at bits 47:39 (level 4) and ending with bits 20:12 (level 1). Bits 11:0 pass through as the offset of a 4 KiB page. Every descriptor holds control flags in its low bits and in bit 63, and the next-table or page frame in bits 51:12. A descriptor at level 3 or level 2 can mark a large page (1 GiB or 2 MiB). In that case the walk ends early and the lower virtual bits become the page offset.

Only one translation is in flight at a time. The requester sees `req_ready` high only while the walker is idle.

Top module: `pgw_walker`

## Requirements
- R1: When virtual address bits 63:48 are not all equal to bit 47, the request completes with fault code 1 and level 0, and no memory read is issued. A sign-extended address with bit 47 set translates normally.
- R2: The descriptor read address for a level is {table frame bits 51:12, the 9-bit index for that level, 3'b000}. The first table frame comes from the root input, and later frames come from bits 51:12 of the previous descriptor. A walk that ends at level 1 takes exactly four reads.
- R3: A level-1 descriptor yields the physical address {descriptor bits 51:12, virtual bits 11:0}. Descriptor bits 62:52 never affect the address.
- R4: A descriptor with bit 0 (present) clear ends the walk with fault code 2 at that level.
- R5: A present level-2 descriptor with bit 7 set ends the walk after three reads with the physical address {descriptor bits 51:21, virtual bits 20:0} and level 2.
- R6: A present level-3 descriptor with bit 7 set ends the walk after two reads with the physical address {descriptor bits 51:30, virtual bits 29:0} and level 3.
- R7: Bit 7 has no effect at level 4 or level 1. Walks through such descriptors still take four reads and use a 4 KiB page.
- R8: A write request faults with code 3 at the first level whose bit 1 (writable) is clear. A read through the same descriptors succeeds.
- R9: A user-mode request faults with code 4 at the first level whose bit 2 (user) is clear. A supervisor request through the same descriptors succeeds.
- R10: An instruction-fetch request faults with code 5 at the final descriptor when that descriptor has bit 63 set, including a large-page descriptor. Bit 63 on a non-final descriptor, or on a final descriptor for a non-fetch request, has no effect.
- R11: Within one descriptor, the not-present fault wins over the write fault, and the write fault wins over the user fault.
- R12: `done` is high for exactly one cycle per accepted request. `req_ready` is low from acceptance until after `done`. On success the result gives fault code 0, `res_fault` low and the level where the walk ended. On a fault the physical address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical base of the level-4 table (bits 11:0 ignored) |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor read data |
| done | output | 1 | One-cycle completion pulse |
| res_paddr | output | 52 | Translated physical address |
| res_fault | output | 1 | Translation faulted |
| res_fault_code | output | 3 | 0 none, 1 non-canonical, 2 not present, 3 write, 4 user, 5 fetch |
| res_fault_level | output | 3 | Level where the walk ended (0 for non-canonical) |

## Verification
The bench builds real tables in a sparse memory model that stalls the read handshake, then aims at the edges of the walk. A non-canonical address that reached memory would show a nonzero read count, and a wrong canonical test would also reject high-half addresses. A large-page decode on the wrong level, or bit 7 honoured at level 4 or level 1, gives the wrong read count and a mis-merged offset. An execute-disable check applied to upper levels, or skipped on large pages, flips the fetch results. Shuffled fault priority within a descriptor returns the wrong code.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int VA_W       = 48;
    localparam int FULL_VA_W  = 64;
    localparam int PA_W       = 52;
    localparam int ENTRY_W    = 64;
    localparam int PG_SHIFT   = 12;
    localparam int IDX_W      = 9;
    localparam int LEVELS     = 4;
    localparam int ENTRY_BYTES_LOG2 = 3;
    localparam int FRAME_W    = PA_W - PG_SHIFT;
    localparam int LVL_W      = 3;
    localparam int LVL_SEL_W  = $clog2(LEVELS);

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_LARGE   = 7;
    localparam int BIT_NOEXEC  = 63;

    localparam int LARGE_LVL_LO = 2;
    localparam int LARGE_LVL_HI = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_CANON = 3'd1,
        FLT_NP    = 3'd2,
        FLT_WR    = 3'd3,
        FLT_USER  = 3'd4,
        FLT_EXEC  = 3'd5
    } fault_e;

    typedef struct packed {
        logic write;
        logic user;
        logic fetch;
    } access_t;

    function automatic logic is_canonical(input logic [FULL_VA_W-1:0] va);
        return (&va[FULL_VA_W-1:VA_W-1]) || ~(|va[FULL_VA_W-1:VA_W-1]);
    endfunction

    function automatic logic [PA_W-1:0] leaf_paddr(input logic [ENTRY_W-1:0] e,
                                                   input logic [VA_W-1:0] va,
                                                   input lvl_t lvl);
        logic [PA_W-1:0] keep;
        int              sh;
        sh   = PG_SHIFT + IDX_W * (int'(lvl) - 1);
        keep = (PA_W'(1) << sh) - PA_W'(1);
        return ({e[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}} & ~keep) | (PA_W'(va) & keep);
    endfunction

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
    import pgw_pkg::*;
(
    input  logic [FRAME_W-1:0] frame,
    input  logic [VA_W-1:0]    vaddr,
    input  lvl_t               level,
    output logic [PA_W-1:0]    entry_addr
);

    logic [IDX_W-1:0]     idx_by_lvl [LEVELS];
    logic [LVL_SEL_W-1:0] sel;
    logic [IDX_W-1:0]     idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign idx_by_lvl[g] = vaddr[PG_SHIFT + IDX_W*g +: IDX_W];
    end

    assign sel        = LVL_SEL_W'(level - lvl_t'(1));
    assign idx        = idx_by_lvl[sel];
    assign entry_addr = {frame, idx, {ENTRY_BYTES_LOG2{1'b0}}};

endmodule

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
    import pgw_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  lvl_t               level,
    input  access_t            acc,
    output fault_e             fault,
    output logic               leaf
);

    logic large_ok;

    assign large_ok = (level >= lvl_t'(LARGE_LVL_LO)) && (level <= lvl_t'(LARGE_LVL_HI));
    assign leaf     = (level == lvl_t'(1)) || (large_ok && entry[BIT_LARGE]);

    always_comb begin
        if (!entry[BIT_PRESENT]) begin
            fault = FLT_NP;
        end else if (acc.write && !entry[BIT_WRITE]) begin
            fault = FLT_WR;
        end else if (acc.user && !entry[BIT_USER]) begin
            fault = FLT_USER;
        end else if (leaf && acc.fetch && entry[BIT_NOEXEC]) begin
            fault = FLT_EXEC;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [FULL_VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0]      req_root,
    input  logic                 req_write,
    input  logic                 req_user,
    input  logic                 req_fetch,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_W-1:0]      mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ENTRY_W-1:0]   mem_rsp_data,
    output logic                 done,
    output logic [PA_W-1:0]      res_paddr,
    output logic                 res_fault,
    output logic [2:0]           res_fault_code,
    output logic [LVL_W-1:0]     res_fault_level
);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

    state_e             st;
    logic [VA_W-1:0]    va_q;
    access_t            acc_q;
    lvl_t               lvl_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PA_W-1:0]    pa_q;
    fault_e             code_q;
    lvl_t               rlvl_q;

    fault_e             ev_fault;
    logic               ev_leaf;
    logic               req_canon;

    assign req_canon = is_canonical(req_vaddr);

    pgw_addr_gen u_addr (
        .frame      (frame_q),
        .vaddr      (va_q),
        .level      (lvl_q),
        .entry_addr (mem_req_addr)
    );

    pgw_entry_eval u_eval (
        .entry (mem_rsp_data),
        .level (lvl_q),
        .acc   (acc_q),
        .fault (ev_fault),
        .leaf  (ev_leaf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            va_q    <= '0;
            acc_q   <= '0;
            lvl_q   <= '0;
            frame_q <= '0;
            pa_q    <= '0;
            code_q  <= FLT_NONE;
            rlvl_q  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr[VA_W-1:0];
                        acc_q   <= '{write: req_write, user: req_user, fetch: req_fetch};
                        lvl_q   <= lvl_t'(LEVELS);
                        frame_q <= req_root[PA_W-1:PG_SHIFT];
                        if (!req_canon) begin
                            code_q <= FLT_CANON;
                            rlvl_q <= '0;
                            pa_q   <= '0;
                            st     <= S_DONE;
                        end else begin
                            st <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (mem_req_ready) st <= S_WAIT;
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ev_fault != FLT_NONE) begin
                            code_q <= ev_fault;
                            rlvl_q <= lvl_q;
                            pa_q   <= '0;
                            st     <= S_DONE;
                        end else if (ev_leaf) begin
                            code_q <= FLT_NONE;
                            rlvl_q <= lvl_q;
                            pa_q   <= leaf_paddr(mem_rsp_data, va_q, lvl_q);
                            st     <= S_DONE;
                        end else begin
                            frame_q <= mem_rsp_data[PA_W-1:PG_SHIFT];
                            lvl_q   <= lvl_q - lvl_t'(1);
                            st      <= S_ISSUE;
                        end
                    end
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready       = (st == S_IDLE);
    assign mem_req_valid   = (st == S_ISSUE);
    assign done            = (st == S_DONE);
    assign res_paddr       = pa_q;
    assign res_fault_code  = code_q;
    assign res_fault       = (code_q != FLT_NONE);
    assign res_fault_level = rlvl_q;

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R1
    canon_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_canon) |=>
            (done && res_fault_code == 3'(FLT_CANON) && res_fault_level == '0));

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R7
    last_level_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && mem_rsp_valid && lvl_q == lvl_t'(1)) |=> done);

    // R12
    success_level_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !res_fault) |-> (res_fault_level != '0));

endmodule

// File: tb/test_pgw_walker.sv
module test_pgw_walker;

    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] FP  = 64'h1;
    localparam logic [63:0] FW  = 64'h2;
    localparam logic [63:0] FU  = 64'h4;
    localparam logic [63:0] FPS = 64'h80;
    localparam logic [63:0] FXD = 64'h8000_0000_0000_0000;
    localparam logic [63:0] FULL = FP | FW | FU;
    localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [51:0] req_root = ROOT;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_fetch = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [51:0] res_paddr;
    logic        res_fault;
    logic [2:0]  res_fault_code;
    logic [2:0]  res_fault_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_walker i_pgw_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_root(req_root), .req_write(req_write), .req_user(req_user),
        .req_fetch(req_fetch),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .res_paddr(res_paddr), .res_fault(res_fault),
        .res_fault_code(res_fault_code), .res_fault_level(res_fault_level)
    );

    int checks = 0;
    int failures = 0;
    int rd_total = 0;
    int cyc = 0;
    logic [63:0] mem [logic [51:0]];
    logic [51:0] addr_log [$];
    logic [51:0] next_tbl = 52'h0_0000_0020_0000;
    logic [51:0] last_tbl;

    typedef struct {
        string       tag;
        logic [51:0] pa;
        int          code;
        int          lvl;
        int          reads;
        int          rd_base;
    } exp_t;
    exp_t sb [$];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model with a stalling accept and one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            rd_total      <= rd_total + 1;
            addr_log.push_back(mem_req_addr);
        end
    end

    // Scoreboard monitor
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done && done) chk("R12 done lasted more than one cycle", 1, 0);
            if (done) begin
                if (sb.size() == 0) begin
                    chk("R12 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " code"},  64'(res_fault_code), 64'(e.code));
                    chk({e.tag, " fault"}, 64'(res_fault),      64'(e.code != 0));
                    chk({e.tag, " level"}, 64'(res_fault_level), 64'(e.lvl));
                    chk({e.tag, " paddr"}, 64'(res_paddr),      64'(e.pa));
                    chk({e.tag, " reads"}, 64'(rd_total - e.rd_base), 64'(e.reads));
                end
            end
        end
        prev_done = done;
    end

    function automatic logic [63:0] mkva(input int i4, input int i3, input int i2,
                                         input int i1, input int off);
        logic [8:0] a;
        a = 9'(i4);
        return {{16{a[8]}}, a, 9'(i3), 9'(i2), 9'(i1), 12'(off)};
    endfunction

    // Builds a fresh walk from ROOT down to leaf level lv
    task automatic install(input logic [63:0] va, input int lv, input logic [51:0] pa,
                           input logic [63:0] f4, input logic [63:0] f3,
                           input logic [63:0] f2, input logic [63:0] f1);
        logic [51:0] base;
        logic [63:0] fl;
        base = ROOT;
        for (int l = 4; l >= lv; l--) begin
            logic [51:0] a;
            a  = {base[51:12], va[12 + 9*(l-1) +: 9], 3'b000};
            fl = (l == 4) ? f4 : (l == 3) ? f3 : (l == 2) ? f2 : f1;
            if (l == lv) begin
                mem[a] = {12'h0, pa} | fl;
                last_tbl = base;
            end else begin
                mem[a] = {12'h0, next_tbl} | fl;
                base = next_tbl;
                next_tbl = next_tbl + 52'h1000;
            end
        end
    endtask

    task automatic run(input string tag, input logic [63:0] va, input bit w, input bit u,
                       input bit f, input logic [51:0] pa, input int code, input int lvl,
                       input int reads);
        exp_t e;
        @(negedge clk);
        e.tag = tag; e.pa = pa; e.code = code; e.lvl = lvl; e.reads = reads;
        e.rd_base = rd_total;
        sb.push_back(e);
        addr_log.delete();
        req_vaddr = va; req_write = w; req_user = u; req_fetch = f;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R12 ready low while busy"}, 64'(req_ready), 0);
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset req_ready", 64'(req_ready), 1);
        chk("reset done", 64'(done), 0);
        chk("reset mem_req_valid", 64'(mem_req_valid), 0);

        // R1 non-canonical: bit 47 set, upper zero; and bit 48 alone
        run("R1 noncanon a", 64'h0000_8000_0000_0000, 0, 0, 0, 52'h0, 1, 0, 0);
        run("R1 noncanon b", 64'h0001_0000_0000_1000, 1, 1, 1, 52'h0, 1, 0, 0);

        // R3/R2 4 KiB leaf with junk in bits 62:52
        install(mkva(1, 2, 3, 4, 0), 1, 52'h0_00AB_CDEF_1000, FULL, FULL, FULL,
                FULL | 64'h7FF0_0000_0000_0000);
        run("R3 4k leaf", mkva(1, 2, 3, 4, 12'hABC), 0, 0, 0, 52'h0_00AB_CDEF_1ABC, 0, 1, 4);
        chk("R2 first entry addr", 64'(addr_log[0]), 64'h10_0008);
        chk("R2 last entry addr", 64'(addr_log[3]), 64'({last_tbl[51:12], 9'd4, 3'b000}));

        // R1 high-half canonical address translates
        install(mkva(256 + 3, 5, 6, 7, 0), 1, 52'h0_0000_5555_5000, FULL, FULL, FULL, FULL);
        run("R1 high canonical", mkva(256 + 3, 5, 6, 7, 12'h010), 0, 0, 0,
            52'h0_0000_5555_5010, 0, 1, 4);

        // R5 2 MiB page
        install(mkva(2, 1, 9, 0, 0), 2, 52'h0_0001_2340_0000, FULL, FULL, FULL | FPS, 0);
        run("R5 2M page", mkva(2, 1, 9, 9'h1A5, 12'h321), 0, 0, 0, 52'h0_0001_235A_5321, 0, 2, 3);

        // R6 1 GiB page
        install(mkva(3, 7, 0, 0, 0), 3, 52'h0_0040_0000_0000, FULL, FULL | FPS, 0, 0);
        run("R6 1G page", mkva(3, 7, 9'h0AB, 9'h0CD, 12'h777), 0, 0, 0, 52'h0_0040_156C_D777, 0, 3, 2);

        // R7 large bit ignored at level 4 and level 1
        install(mkva(4, 1, 1, 1, 0), 1, 52'h7000, FULL | FPS, FULL, FULL, FULL);
        run("R7 ps at L4", mkva(4, 1, 1, 1, 12'h008), 0, 0, 0, 52'h7008, 0, 1, 4);
        install(mkva(5, 1, 1, 1, 0), 1, 52'h9000, FULL, FULL, FULL, FULL | FPS);
        run("R7 ps at L1", mkva(5, 1, 1, 1, 12'h00F), 0, 0, 0, 52'h900F, 0, 1, 4);

        // R4 not present
        run("R4 unmapped L4", mkva(6, 0, 0, 0, 0), 0, 0, 0, 52'h0, 2, 4, 1);
        install(mkva(7, 1, 2, 3, 0), 1, 52'h3000, FULL, FULL, FW | FU, FULL);
        run("R4 absent L2", mkva(7, 1, 2, 3, 0), 0, 0, 0, 52'h0, 2, 2, 3);

        // R8 write permission
        install(mkva(8, 1, 1, 1, 0), 1, 52'hA000, FULL, FP | FU, FULL, FULL);
        run("R8 write denied", mkva(8, 1, 1, 1, 12'h010), 1, 0, 0, 52'h0, 3, 3, 2);
        run("R8 read allowed", mkva(8, 1, 1, 1, 12'h010), 0, 1, 0, 52'hA010, 0, 1, 4);

        // R9 user permission
        install(mkva(9, 1, 1, 1, 0), 1, 52'hB000, FULL, FULL, FP | FW, FULL);
        run("R9 user denied", mkva(9, 1, 1, 1, 12'h020), 0, 1, 0, 52'h0, 4, 2, 3);
        run("R9 supervisor ok", mkva(9, 1, 1, 1, 12'h020), 1, 0, 0, 52'hB020, 0, 1, 4);

        // R10 execute-disable
        install(mkva(10, 1, 1, 1, 0), 1, 52'hC000, FULL, FULL, FULL, FULL | FXD);
        run("R10 fetch nx leaf", mkva(10, 1, 1, 1, 12'h030), 0, 1, 1, 52'h0, 5, 1, 4);
        run("R10 read nx leaf", mkva(10, 1, 1, 1, 12'h030), 0, 1, 0, 52'hC030, 0, 1, 4);
        install(mkva(11, 1, 1, 1, 0), 1, 52'hD000, FULL | FXD, FULL, FULL, FULL);
        run("R10 nx upper only", mkva(11, 1, 1, 1, 12'h040), 0, 0, 1, 52'hD040, 0, 1, 4);
        install(mkva(12, 1, 1, 0, 0), 2, 52'h20_0000, FULL, FULL, FULL | FPS | FXD, 0);
        run("R10 nx large page", mkva(12, 1, 1, 5, 0), 0, 0, 1, 52'h0, 5, 2, 3);

        // R11 priorities
        install(mkva(13, 1, 1, 1, 0), 1, 52'hE000, FULL, FP, FULL, FULL);
        run("R11 write over user", mkva(13, 1, 1, 1, 0), 1, 1, 0, 52'h0, 3, 3, 2);
        install(mkva(14, 1, 1, 1, 0), 1, 52'hF000, 64'h0, FULL, FULL, FULL);
        run("R11 absent over perms", mkva(14, 1, 1, 1, 0), 1, 1, 1, 52'h0, 2, 4, 1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule